// File: doc/BRIEF.md
# Hash Engine Interrupt Controller

This block turns status from a hash accelerator into three interrupt lines: one for a finished operation, one for an empty message FIFO, and one for an error. Each source has a pending bit in a state register, a mask bit in an enable register, and a bit in a write-only test register. Each interrupt line is the registered AND of its pending bit and its mask bit.

The done and error pending bits latch single-cycle event pulses from the engine. Software clears them by writing 1. The FIFO-empty pending bit is different: software cannot clear it. It is raised only when software is the one feeding the FIFO, that is:
- the sponge is absorbing,
- the hardware application port does not own the engine,
- the process command has not yet been issued.

It also requires that the FIFO was seen full earlier in the same absorb phase. Otherwise an engine that drains faster than software writes would raise an interrupt that carries no information.

A small register port gives access to the three registers: a word address, a write strobe, write data and a combinational read-data bus. Register map: word 0 is state, word 1 is enable, word 2 is test. In every register, bit 0 is done, bit 1 is FIFO-empty and bit 2 is error.

Top module: `hash_irq_ctrl`

## Requirements
- R1: After reset, the state and enable registers read 0 and every interrupt line is 0. The register map is word 0 = state, word 1 = enable, word 2 = test. In each register, bit 0 is done, bit 1 is FIFO-empty and bit 2 is error. Bits 31:3 of every read are 0. The test register always reads 0.
- R2: The done and error pending bits are set by the `evt_done` and `evt_err` pulses. Each is cleared by a write to word 0 that has a 1 in its bit position. A 0 in that position leaves the bit unchanged.
- R3: A write to word 0 never clears the FIFO-empty pending bit.
- R4: The FIFO-empty pending bit becomes 1 one clock after `fifo_empty` is seen, provided that all of the following hold:
  - `app_owned` is 0;
  - `sponge_phase` is absorb (2'd1);
  - `proc_issued` is 0;
  - `fifo_full` was seen high in an earlier cycle of the same absorb phase.
- R5: Once set, the FIFO-empty pending bit stays 1 only while `fifo_empty` and all three qualifiers stay true. It drops in the cycle after any of them goes false.
- R6: Each firing of the FIFO-empty bit uses up the earlier full observation. A new `fifo_full` is needed before the bit can fire again.
- R7: Leaving the absorb phase discards any earlier full observation.
- R8: Writing 1 to a bit of the test register (word 2) sets the matching pending bit on the next clock, whatever the engine inputs are.
- R9: Each interrupt line equals (pending AND enable) as it stood one clock earlier. A masked source never drives its line.
- R10: If a hardware event arrives in the same cycle as a software clear of that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| evt_done | input | 1 | Operation-finished pulse |
| evt_err | input | 1 | Error pulse |
| fifo_full | input | 1 | Message FIFO full flag |
| fifo_empty | input | 1 | Message FIFO empty flag |
| sponge_phase | input | 2 | Sponge phase: 0 idle, 1 absorb, 2 squeeze |
| app_owned | input | 1 | Hardware application port owns the engine |
| proc_issued | input | 1 | Process command already issued |
| irq | output | 3 | Interrupt lines: {error, FIFO-empty, done} |

## Verification
The bench builds the block with its default parameters: a 2-bit word address and 32-bit data. The full data width exposes the upper read bits, so the bench can check that bits 31:3 always read as zero. The spare fourth address, beyond the three registers, is not exercised. Directed sequences cover each of the following:
- arming the FIFO-empty bit with a full pulse;
- firing it;
- holding it while the FIFO stays empty;
- dropping it when the FIFO refills or a qualifier goes false;
- disarming the full observation when the phase leaves absorb.

The timing of the interrupt lines is checked separately against the moment each pending bit changes.

// File: rtl/hash_irq_ctrl.sv
module hash_irq_ctrl #(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          evt_done,
  input  logic          evt_err,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic [1:0]    sponge_phase,
  input  logic          app_owned,
  input  logic          proc_issued,
  output logic [2:0]    irq
);
  localparam int NSRC = 3;
  localparam logic [AW-1:0] A_STATE = AW'(0);
  localparam logic [AW-1:0] A_EN    = AW'(1);
  localparam logic [AW-1:0] A_TEST  = AW'(2);
  localparam logic [1:0] PH_ABSORB  = 2'd1;

  logic [NSRC-1:0] pend_q, mask_q, irq_q;
  logic            armed_q;
  logic [NSRC-1:0] clr_w, tst_w;
  logic            sw_feeds, fire, absorbing;
  logic            unused_w;

  assign unused_w  = ^reg_wdata[DW-1:NSRC];
  assign clr_w     = (reg_we && reg_addr == A_STATE) ? reg_wdata[NSRC-1:0] : '0;
  assign tst_w     = (reg_we && reg_addr == A_TEST)  ? reg_wdata[NSRC-1:0] : '0;
  assign absorbing = (sponge_phase == PH_ABSORB);
  assign sw_feeds  = absorbing && !app_owned && !proc_issued;
  assign fire      = sw_feeds && armed_q && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed_q <= 1'b0;
    else if (!absorbing)    armed_q <= 1'b0;
    else if (fire)          armed_q <= 1'b0;
    else if (fifo_full)     armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= '0;
    end else begin
      pend_q[0] <= evt_done | tst_w[0] | (pend_q[0] & ~clr_w[0]);
      pend_q[2] <= evt_err  | tst_w[2] | (pend_q[2] & ~clr_w[2]);
      pend_q[1] <= fire | tst_w[1] | (pend_q[1] & fifo_empty & sw_feeds);
      if (reg_we && reg_addr == A_EN) mask_q <= reg_wdata[NSRC-1:0];
      irq_q <= pend_q & mask_q;
    end
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATE: reg_rdata[NSRC-1:0] = pend_q;
      A_EN:    reg_rdata[NSRC-1:0] = mask_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hash_irq_ctrl_chk.sv
module hash_irq_ctrl_chk #(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          evt_done,
  input logic          fifo_empty,
  input logic [1:0]    sponge_phase,
  input logic          app_owned,
  input logic          proc_issued,
  input logic [2:0]    pend_q,
  input logic [2:0]    mask_q,
  input logic          armed_q,
  input logic [2:0]    irq
);
  logic tst1, qual;
  assign tst1 = reg_we && reg_addr == AW'(2) && reg_wdata[1];
  assign qual = sponge_phase == 2'd1 && !app_owned && !proc_issued;

  always_comb begin
    if (rst_n) a_r1_upper_zero: assert (reg_rdata[DW-1:3] == '0);
  end

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> pend_q[0]);

  a_r3_no_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[1] && fifo_empty && qual) |=> pend_q[1]);

  a_r5_drop_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    (!tst1 && !(fifo_empty && qual)) |=> !pend_q[1]);

  a_r4_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!tst1 && !armed_q && !pend_q[1]) |=> !pend_q[1]);

  a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (sponge_phase != 2'd1) |=> !armed_q);

  a_r8_test_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tst1 |=> pend_q[1]);

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && mask_q[0]) |=> irq[0]);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[2] |=> !irq[2]);
endmodule

bind hash_irq_ctrl hash_irq_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
  .fifo_empty(fifo_empty), .sponge_phase(sponge_phase), .app_owned(app_owned),
  .proc_issued(proc_issued), .pend_q(pend_q), .mask_q(mask_q),
  .armed_q(armed_q), .irq(irq)
);

// File: tb/hash_irq_ctrl_bench.sv
`timescale 1ns/1ps
module hash_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_done = 1'b0, evt_err = 1'b0;
  logic        fifo_full = 1'b0, fifo_empty = 1'b0;
  logic [1:0]  sponge_phase = 2'd0;
  logic        app_owned = 1'b0, proc_issued = 1'b0;
  logic [2:0]  irq;
  int n_chk = 0, n_bad = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  hash_irq_ctrl u_hash_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
    .evt_err(evt_err), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .sponge_phase(sponge_phase), .app_owned(app_owned),
    .proc_issued(proc_issued), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 state reset", d, 0);
    rd(2'd1, d); chk("R1 enable reset", d, 0);
    chk("R1 irq reset", {29'b0, irq}, 0);
    wr(2'd1, 32'hFFFF_FFF8);
    rd(2'd1, d); chk("R1 upper bits zero", d, 0);
    rd(2'd2, d); chk("R1 test reads zero", d, 0);
  endtask

  task automatic t_done_err();
    logic [31:0] d;
    evt_done = 1'b1; step(); evt_done = 1'b0;
    rd(2'd0, d); chk("R2 done set", d, 32'h1);
    step(); chk("R9 masked irq low", {29'b0, irq}, 0);
    wr(2'd1, 32'h5);
    chk("R9 irq not yet", {29'b0, irq}, 0);
    step(); chk("R9 irq done high", {29'b0, irq}, 32'h1);
    wr(2'd0, 32'h4);
    rd(2'd0, d); chk("R2 zero bit keeps done", d, 32'h1);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R2 done cleared", d, 0);
    step(); chk("R9 irq follows clear", {29'b0, irq}, 0);
    evt_err = 1'b1; step(); evt_err = 1'b0;
    rd(2'd0, d); chk("R2 err set", d, 32'h4);
    step(); chk("R9 irq err", {29'b0, irq}, 32'h4);
    evt_err = 1'b1; wr(2'd0, 32'h4); evt_err = 1'b0;
    rd(2'd0, d); chk("R10 event beats clear", d, 32'h4);
    wr(2'd0, 32'h4);
    rd(2'd0, d); chk("R2 err cleared", d, 0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_empty_path();
    logic [31:0] d;
    sponge_phase = 2'd1; fifo_empty = 1'b1; step(); step();
    rd(2'd0, d); chk("R4 no fire without full", d, 0);
    fifo_empty = 1'b0; fifo_full = 1'b1; step();
    fifo_full = 1'b0; fifo_empty = 1'b1; step();
    rd(2'd0, d); chk("R4 fire after full", d, 32'h2);
    wr(2'd0, 32'h2);
    rd(2'd0, d); chk("R3 sw write ignored", d, 32'h2);
    step(); rd(2'd0, d); chk("R5 holds while empty", d, 32'h2);
    fifo_empty = 1'b0; step();
    rd(2'd0, d); chk("R5 drops when refilled", d, 0);
    fifo_empty = 1'b1; step();
    rd(2'd0, d); chk("R6 rearm needed", d, 0);
    fifo_empty = 1'b0; fifo_full = 1'b1; step();
    fifo_full = 1'b0; proc_issued = 1'b1; fifo_empty = 1'b1; step();
    rd(2'd0, d); chk("R4 blocked by process", d, 0);
    proc_issued = 1'b0; app_owned = 1'b1; step();
    rd(2'd0, d); chk("R4 blocked by app port", d, 0);
    app_owned = 1'b0; step();
    rd(2'd0, d); chk("R4 fires once qualified", d, 32'h2);
    proc_issued = 1'b1; step();
    rd(2'd0, d); chk("R5 drops on process", d, 0);
    proc_issued = 1'b0; fifo_empty = 1'b0; fifo_full = 1'b1; step();
    fifo_full = 1'b0; sponge_phase = 2'd2; step();
    sponge_phase = 2'd1; fifo_empty = 1'b1; step();
    rd(2'd0, d); chk("R7 phase exit disarms", d, 0);
    fifo_empty = 1'b0; sponge_phase = 2'd0; step();
  endtask

  task automatic t_test_reg();
    logic [31:0] d;
    wr(2'd1, 32'h2);
    wr(2'd2, 32'h7);
    rd(2'd0, d); chk("R8 test forces all", d, 32'h7);
    step(); rd(2'd0, d); chk("R8 empty bit unqualified drops", d, 32'h5);
    chk("R9 irq from forced empty", {29'b0, irq}, 32'h2);
    step(); chk("R9 irq empty released", {29'b0, irq}, 0);
    wr(2'd0, 32'h5);
    rd(2'd0, d); chk("R2 cleared after test", d, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_done_err();
    t_empty_path();
    t_test_reg();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule